// File: doc/BRIEF.md
# Receive Packet Output Formatter

This block sits behind a Reed-Solomon decoder on the receive side of a modem. The decoder delivers every byte of each decoded packet, in order, with a single-cycle `in_valid` strobe. The first byte of each packet is the sync byte, and the `in_ok` bit given with that byte says whether the packet was correctable and is now free of errors. Each byte is written, together with its `in_ok` bit, into an internal FIFO that can hold more than one packet. The formatter then streams each buffered packet onto a byte bus whose clock, `out_clk`, pulses only for bytes that are being presented.

Each byte on the bus carries three qualifiers. A sync strobe marks the first byte of a packet. A data flag marks payload bytes. A packet-good flag is held for every byte of the packet it describes. The packet length is one sync byte, then the payload, then sixteen parity bytes. The payload is 238 bytes in the 255-byte mode and 223 bytes in the 240-byte mode. Parity bytes are always forwarded unchanged.

The sequencer is a four-state machine:
- `ST_IDLE` goes to `ST_SYNC` once a whole packet is buffered. At that point it latches `sync_mode`.
- `ST_SYNC` always goes to `ST_PAYLOAD`, and latches the packet-good bit.
- `ST_PAYLOAD` goes to `ST_PARITY` after the last payload byte.
- `ST_PARITY`, after the sixteenth parity byte, goes back to `ST_SYNC` if the next whole packet is already buffered, and otherwise to `ST_IDLE`.

Top module: `rx_pkt_formatter`

## Requirements
- R1: While reset is asserted, and after it is released until the first packet starts, `out_clk` stays low, `out_sync`, `out_data_flag` and `out_pkt_good` are 0, and `out_data` is 0.
- R2: With `sync_mode` = 0, a packet is 255 bytes on the bus: 1 sync byte, 238 payload bytes and 16 parity bytes.
- R3: With `sync_mode` = 1, a packet is 240 bytes on the bus: 1 sync byte, 223 payload bytes and 16 parity bytes.
- R4: `out_sync` is 1 only for the first byte of a packet. `out_data_flag` is 1 for payload bytes and 0 for the sync byte and for parity bytes. The two are never 1 together.
- R5: `out_pkt_good` equals the `in_ok` value given with the packet's first input byte. It is held on every byte of that packet, `in_ok` on the later bytes has no effect, and it is 0 when no byte is presented.
- R6: `out_clk` gives exactly one high pulse, during the high phase of `clk`, for each byte presented. While no byte is presented it stays low and all qualifiers are 0.
- R7: `out_data` and the qualifiers change only on a falling edge of `clk`, so they are stable for the whole high phase of `out_clk`.
- R8: A packet starts only after all of its bytes are in the FIFO. Once its sync byte is out, its remaining bytes follow on consecutive cycles with no gap.
- R9: Bytes leave in the order they arrived, with their values unchanged, parity bytes included.
- R10: `sync_mode` is sampled when a packet starts. Changing it while that packet is being streamed does not change the packet's length or flag pattern.
- R11: When the next packet is already fully buffered as the last parity byte goes out, its sync byte follows on the very next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Processing clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| sync_mode | input | 1 | Packet length select: 0 = 255-byte, 1 = 240-byte |
| in_valid | input | 1 | Decoded byte present this cycle |
| in_data | input | 8 | Decoded byte |
| in_ok | input | 1 | Packet-correct bit, taken from the packet's first byte |
| out_clk | output | 1 | Gated copy of `clk`, pulsing once per presented byte |
| out_data | output | 8 | Output byte, changing on the falling edge |
| out_sync | output | 1 | High while the sync byte is presented |
| out_data_flag | output | 1 | High while a payload byte is presented |
| out_pkt_good | output | 1 | High on every byte of a correct packet |

## Verification
The assertions assume that the decoder never writes into a full FIFO, and that the input stream stays aligned to packet boundaries from reset, so that every packet's first byte is its sync byte. The stimulus honours both. It writes whole packets only, in the length that matches the `sync_mode` in force when each packet is written. It never has more than two packets outstanding, well within the 512-entry default depth. Within these limits the gap and hold properties on the output side depend only on the sequencer waiting for a complete packet. The stimulus exercises that wait with slowly written packets, back-to-back packets, and a mode change in the middle of a packet.

// File: rtl/rxfmt_pkg.sv
`timescale 1ns/1ps
package rxfmt_pkg;
    localparam int unsigned DEF_PARITY_BYTES = 16;
    localparam int unsigned DEF_PAYLOAD_INT  = 238;
    localparam int unsigned DEF_PAYLOAD_EXT  = 223;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_SYNC,
        ST_PAYLOAD,
        ST_PARITY
    } fmt_state_e;

    typedef enum logic [1:0] {
        BYTE_NONE,
        BYTE_SYNC,
        BYTE_DATA,
        BYTE_CHECK
    } byte_kind_e;
endpackage

// File: rtl/rxfmt_fifo.sv
`timescale 1ns/1ps
module rxfmt_fifo #(
    parameter int unsigned WIDTH = 9,
    parameter int unsigned DEPTH = 512,
    localparam int unsigned AW = $clog2(DEPTH),
    localparam int unsigned CW = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic [WIDTH-1:0] wdata,
    input  logic             pop,
    output logic [WIDTH-1:0] rdata,
    output logic [CW-1:0]    count
);
    logic [WIDTH-1:0] mem [DEPTH];
    logic [AW-1:0]    wr_ptr;
    logic [AW-1:0]    rd_ptr;

    always_ff @(posedge clk) begin
        if (push) begin
            mem[wr_ptr] <= wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (push) begin
                wr_ptr <= (wr_ptr == AW'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
            end
            if (pop) begin
                rd_ptr <= (rd_ptr == AW'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
            end
            unique case ({push, pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    assign rdata = mem[rd_ptr];

    // Input assumption: the decoder never writes into a full buffer (R8).
    assert_no_overflow_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (push && !pop) |-> (count < CW'(DEPTH)));

    // The sequencer only reads bytes that are present (R8).
    assert_no_underflow_R8: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> (count != '0));
endmodule

// File: rtl/rxfmt_seq.sv
`timescale 1ns/1ps
module rxfmt_seq
    import rxfmt_pkg::*;
#(
    parameter int unsigned CW           = 10,
    parameter int unsigned PAYLOAD_INT  = DEF_PAYLOAD_INT,
    parameter int unsigned PAYLOAD_EXT  = DEF_PAYLOAD_EXT,
    parameter int unsigned PARITY_BYTES = DEF_PARITY_BYTES,
    localparam int unsigned LEN_INT = 1 + PAYLOAD_INT + PARITY_BYTES,
    localparam int unsigned LEN_EXT = 1 + PAYLOAD_EXT + PARITY_BYTES,
    localparam int unsigned MAX_PL  = (PAYLOAD_INT > PAYLOAD_EXT) ? PAYLOAD_INT : PAYLOAD_EXT,
    localparam int unsigned MAX_RUN = (MAX_PL > PARITY_BYTES) ? MAX_PL : PARITY_BYTES,
    localparam int unsigned PW      = $clog2(MAX_RUN + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          sync_mode,
    input  logic [CW-1:0] fifo_count,
    input  logic          fifo_ok,
    output logic          pop,
    output byte_kind_e    kind,
    output logic          pkt_ok
);
    fmt_state_e    state;
    fmt_state_e    nxt_state;
    logic [PW-1:0] pos;
    logic          mode_q;
    logic          ok_q;
    logic [CW-1:0] need_now;
    logic [PW-1:0] payload_last;
    logic          parity_last;

    assign need_now     = sync_mode ? CW'(LEN_EXT) : CW'(LEN_INT);
    assign payload_last = mode_q ? PW'(PAYLOAD_EXT - 1) : PW'(PAYLOAD_INT - 1);
    assign parity_last  = (pos == PW'(PARITY_BYTES - 1));

    always_comb begin
        nxt_state = state;
        unique case (state)
            ST_IDLE:    if (fifo_count >= need_now) nxt_state = ST_SYNC;
            ST_SYNC:    nxt_state = ST_PAYLOAD;
            ST_PAYLOAD: if (pos == payload_last) nxt_state = ST_PARITY;
            ST_PARITY:  if (parity_last) nxt_state = (fifo_count > need_now) ? ST_SYNC : ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state  <= ST_IDLE;
            pos    <= '0;
            mode_q <= 1'b0;
            ok_q   <= 1'b0;
        end else begin
            state <= nxt_state;
            if (nxt_state == ST_SYNC) begin
                mode_q <= sync_mode;
            end
            unique case (state)
                ST_IDLE:    pos <= '0;
                ST_SYNC:    begin pos <= '0; ok_q <= fifo_ok; end
                ST_PAYLOAD: pos <= (pos == payload_last) ? '0 : pos + 1'b1;
                ST_PARITY:  pos <= pos + 1'b1;
            endcase
        end
    end

    always_comb begin
        pop  = 1'b1;
        kind = BYTE_NONE;
        unique case (state)
            ST_IDLE:    begin pop = 1'b0; kind = BYTE_NONE; end
            ST_SYNC:    kind = BYTE_SYNC;
            ST_PAYLOAD: kind = BYTE_DATA;
            ST_PARITY:  kind = BYTE_CHECK;
        endcase
    end

    assign pkt_ok = (state == ST_SYNC) ? fifo_ok : ok_q;

    // A packet is launched only with all of its bytes buffered (R8).
    assert_whole_packet_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SYNC) |-> (fifo_count >= (mode_q ? CW'(LEN_EXT) : CW'(LEN_INT))));
endmodule

// File: rtl/rxfmt_launch.sv
`timescale 1ns/1ps
module rxfmt_launch
    import rxfmt_pkg::*;
#(
    parameter int unsigned DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  byte_kind_e        kind,
    input  logic [DATA_W-1:0] data,
    input  logic              pkt_ok,
    output logic              out_clk,
    output logic [DATA_W-1:0] out_data,
    output logic              out_sync,
    output logic              out_flag,
    output logic              out_good
);
    logic is_byte;
    logic is_sync;
    logic is_data;
    logic gate_q;

    always_comb begin
        is_byte = 1'b1;
        is_sync = 1'b0;
        is_data = 1'b0;
        unique case (kind)
            BYTE_NONE:  is_byte = 1'b0;
            BYTE_SYNC:  is_sync = 1'b1;
            BYTE_DATA:  is_data = 1'b1;
            BYTE_CHECK: is_byte = 1'b1;
        endcase
    end

    // Falling-edge launch: everything settles while clk is low.
    always_ff @(negedge clk or negedge rst_n) begin
        if (!rst_n) begin
            gate_q   <= 1'b0;
            out_data <= '0;
            out_sync <= 1'b0;
            out_flag <= 1'b0;
            out_good <= 1'b0;
        end else begin
            gate_q   <= is_byte;
            out_sync <= is_sync;
            out_flag <= is_data;
            out_good <= is_byte & pkt_ok;
            if (is_byte) begin
                out_data <= data;
            end
        end
    end

    assign out_clk = clk & gate_q;

    assert_sync_flag_excl_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !(out_sync && out_flag));

    assert_idle_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !gate_q |-> !(out_sync || out_flag || out_good));

    assert_no_gap_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (gate_q && !out_sync) |-> $past(gate_q));

    assert_good_held_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (gate_q && !out_sync) |-> $stable(out_good));
endmodule

// File: rtl/rx_pkt_formatter.sv
`timescale 1ns/1ps
module rx_pkt_formatter
    import rxfmt_pkg::*;
#(
    parameter int unsigned DATA_W       = 8,
    parameter int unsigned FIFO_DEPTH   = 512,
    parameter int unsigned PAYLOAD_INT  = DEF_PAYLOAD_INT,
    parameter int unsigned PAYLOAD_EXT  = DEF_PAYLOAD_EXT,
    parameter int unsigned PARITY_BYTES = DEF_PARITY_BYTES,
    localparam int unsigned EW = DATA_W + 1,
    localparam int unsigned CW = $clog2(FIFO_DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sync_mode,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] in_data,
    input  logic              in_ok,
    output logic              out_clk,
    output logic [DATA_W-1:0] out_data,
    output logic              out_sync,
    output logic              out_data_flag,
    output logic              out_pkt_good
);
    logic [EW-1:0] head;
    logic [CW-1:0] fill;
    logic          pop;
    logic          pkt_ok;
    byte_kind_e    kind;

    rxfmt_fifo #(
        .WIDTH (EW),
        .DEPTH (FIFO_DEPTH)
    ) u_fifo (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (in_valid),
        .wdata ({in_ok, in_data}),
        .pop   (pop),
        .rdata (head),
        .count (fill)
    );

    rxfmt_seq #(
        .CW           (CW),
        .PAYLOAD_INT  (PAYLOAD_INT),
        .PAYLOAD_EXT  (PAYLOAD_EXT),
        .PARITY_BYTES (PARITY_BYTES)
    ) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .sync_mode  (sync_mode),
        .fifo_count (fill),
        .fifo_ok    (head[DATA_W]),
        .pop        (pop),
        .kind       (kind),
        .pkt_ok     (pkt_ok)
    );

    rxfmt_launch #(
        .DATA_W (DATA_W)
    ) u_launch (
        .clk      (clk),
        .rst_n    (rst_n),
        .kind     (kind),
        .data     (head[DATA_W-1:0]),
        .pkt_ok   (pkt_ok),
        .out_clk  (out_clk),
        .out_data (out_data),
        .out_sync (out_sync),
        .out_flag (out_data_flag),
        .out_good (out_pkt_good)
    );
endmodule

// File: tb/rx_pkt_formatter_test.sv
`timescale 1ns/1ps
module rx_pkt_formatter_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sync_mode = 1'b0;
    logic       in_valid = 1'b0;
    logic [7:0] in_data = 8'h00;
    logic       in_ok = 1'b0;
    logic       out_clk;
    logic [7:0] out_data;
    logic       out_sync;
    logic       out_data_flag;
    logic       out_pkt_good;

    always #2.5 clk = ~clk;

    rx_pkt_formatter uut (
        .clk           (clk),
        .rst_n         (rst_n),
        .sync_mode     (sync_mode),
        .in_valid      (in_valid),
        .in_data       (in_data),
        .in_ok         (in_ok),
        .out_clk       (out_clk),
        .out_data      (out_data),
        .out_sync      (out_sync),
        .out_data_flag (out_data_flag),
        .out_pkt_good  (out_pkt_good)
    );

    int total = 0;
    int failed = 0;
    int cyc = 0;

    logic [7:0] exp_data [4096];
    bit         exp_sync [4096];
    bit         exp_flag [4096];
    bit         exp_good [4096];
    int wr_idx = 0;
    int rd_idx = 0;
    int rx_count = 0;
    int last_byte_cyc = -100;
    int last_sync_cyc = 0;
    int last_sync_gap = 0;
    int last_push_cyc = 0;

    // {mode, ok, seed, expected length}
    localparam logic [17:0] VEC [6] = '{
        {1'b0, 1'b1, 8'h10, 8'd255},
        {1'b1, 1'b1, 8'h3C, 8'd240},
        {1'b0, 1'b0, 8'hA5, 8'd255},
        {1'b1, 1'b0, 8'h00, 8'd240},
        {1'b1, 1'b1, 8'hFF, 8'd240},
        {1'b0, 1'b1, 8'h7E, 8'd255}
    };

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        total++;
        if (!ok) begin
            failed++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    always @(posedge clk) cyc++;

    // Output monitor: sample just after the rising edge, recheck before the fall.
    always @(posedge clk) begin
        logic       s_clk, s_sync, s_flag, s_good;
        logic [7:0] s_data;
        #0.5;
        s_clk = out_clk; s_sync = out_sync; s_flag = out_data_flag;
        s_good = out_pkt_good; s_data = out_data;
        if (rst_n) begin
            if (s_clk) begin
                if (rd_idx >= wr_idx) begin
                    check(0, "R6", "unexpected byte", 1, 0);
                end else begin
                    check(s_data == exp_data[rd_idx], "R9", "data", s_data, exp_data[rd_idx]);
                    check(s_sync == exp_sync[rd_idx], "R4", "sync strobe", s_sync, exp_sync[rd_idx]);
                    check(s_flag == exp_flag[rd_idx], "R4", "data flag", s_flag, exp_flag[rd_idx]);
                    check(s_good == exp_good[rd_idx], "R5", "packet good", s_good, exp_good[rd_idx]);
                    if (s_sync) begin
                        last_sync_gap = cyc - last_byte_cyc;
                        last_sync_cyc = cyc;
                    end
                    last_byte_cyc = cyc;
                    rx_count++;
                    rd_idx++;
                end
            end else begin
                check(!(s_sync || s_flag || s_good), "R6", "idle qualifiers", {s_sync, s_flag, s_good}, 0);
                if (rd_idx < wr_idx && !exp_sync[rd_idx]) begin
                    check(0, "R8", "gap inside packet", 0, 1);
                end
            end
        end
        #1.5;
        if (rst_n && s_clk) begin
            check(out_data == s_data && out_sync == s_sync && out_data_flag == s_flag
                  && out_pkt_good == s_good, "R7", "stable in high phase", out_data, s_data);
        end
    end

    task automatic push_pkt(input bit mode, input bit ok, input logic [7:0] seed, input bit slow);
        int pl;
        int len;
        pl  = mode ? 223 : 238;
        len = pl + 17;
        for (int i = 0; i < len; i++) begin
            @(negedge clk);
            in_valid = 1'b1;
            in_data  = seed + 8'(i * 7);
            in_ok    = (i == 0) ? ok : ~ok;
            exp_data[wr_idx] = seed + 8'(i * 7);
            exp_sync[wr_idx] = (i == 0);
            exp_flag[wr_idx] = (i >= 1) && (i <= pl);
            exp_good[wr_idx] = ok;
            wr_idx++;
            if (slow && i != len - 1) begin
                @(negedge clk);
                in_valid = 1'b0;
            end
        end
        @(posedge clk);
        #0.2;
        last_push_cyc = cyc;
    endtask

    task automatic stop_push();
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic drain();
        while (rd_idx != wr_idx) @(posedge clk);
        repeat (4) @(posedge clk);
    endtask

    initial begin
        int base;
        repeat (3) @(posedge clk);
        #1;
        check(out_clk == 1'b0, "R1", "out_clk in reset", out_clk, 0);
        check({out_sync, out_data_flag, out_pkt_good} == 3'b000, "R1", "flags in reset",
              {out_sync, out_data_flag, out_pkt_good}, 0);
        check(out_data == 8'h00, "R1", "data in reset", out_data, 0);
        @(negedge clk);
        rst_n = 1'b1;
        repeat (5) @(posedge clk);
        #1;
        check(out_clk == 1'b0 && out_data == 8'h00, "R1", "quiet after reset", out_clk, 0);

        // Table-driven packets
        for (int v = 0; v < 6; v++) begin
            @(negedge clk);
            sync_mode = VEC[v][17];
            base = rx_count;
            push_pkt(VEC[v][17], VEC[v][16], VEC[v][15:8], 1'b0);
            stop_push();
            drain();
            if (VEC[v][17])
                check(rx_count - base == int'(VEC[v][7:0]), "R3", "240-byte length", rx_count - base, VEC[v][7:0]);
            else
                check(rx_count - base == int'(VEC[v][7:0]), "R2", "255-byte length", rx_count - base, VEC[v][7:0]);
        end

        // R8: slowly written packet must not start before its last byte
        @(negedge clk);
        sync_mode = 1'b1;
        push_pkt(1'b1, 1'b1, 8'h21, 1'b1);
        stop_push();
        drain();
        check(last_sync_cyc > last_push_cyc, "R8", "start after full packet", last_sync_cyc, last_push_cyc + 1);

        // R10: mode change while a packet is being streamed
        @(negedge clk);
        sync_mode = 1'b0;
        base = rx_count;
        push_pkt(1'b0, 1'b0, 8'h5A, 1'b0);
        stop_push();
        while (rx_count == base) @(posedge clk);
        @(negedge clk);
        sync_mode = 1'b1;
        drain();
        check(rx_count - base == 255, "R10", "length kept after mode change", rx_count - base, 255);
        @(negedge clk);
        sync_mode = 1'b0;

        // R11: back-to-back packets
        base = rx_count;
        push_pkt(1'b0, 1'b1, 8'h90, 1'b0);
        push_pkt(1'b0, 1'b0, 8'h33, 1'b0);
        stop_push();
        drain();
        check(rx_count - base == 510, "R11", "two packets out", rx_count - base, 510);
        check(last_sync_gap == 1, "R11", "sync right after parity", last_sync_gap, 1);

        $display("%0d/%0d checks passed", total - failed, total);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        total++;
        failed++;
        $display("FAIL R6 watchdog expired: actual %0d expected %0d", cyc, 0);
        $display("%0d/%0d checks passed", total - failed, total);
        $finish;
    end
endmodule